// File: doc/BRIEF.md
# Timecode-Triggered GPI Event Output

This block turns a decoded timecode stream into a general-purpose output event. Each incoming frame strobe carries an eight-digit packed BCD time (hours, minutes, seconds, frames) and a direction flag. The block compares that time against an active target time under a programmable condition. When the condition changes from false to true, it drives its output with one of eight signal behaviours: a static level, a recurrent pulse, a one-shot pulse or a one-shot edge. Pulse lengths are counted in ticks of an external millisecond strobe.

The host writes the target time in two halves, first hours:minutes and then seconds:frames, into staging registers. The target only becomes active when an initialise command is issued with its load flag set. An initialise without the load flag leaves the target unchanged. It still re-arms the block and returns the output to its idle level. One mode byte sets the behaviour:

- bits 2..0: output kind
- bit 3: whether the frame digits are included in the comparison
- bits 5..4: the comparison condition
- bits 7..6: the pulse width

The sequencer has four named states:

- `SQ_IDLE`: the output sits at its idle level.
- `SQ_PULSE`: a pulse is running.
- `SQ_HOLD`: an edge mode has switched its level and holds it.
- `SQ_SPENT`: a one-shot pulse has finished and the block ignores further events.

Transitions:

- `SQ_IDLE` to `SQ_PULSE` on an event in pulse modes.
- `SQ_IDLE` to `SQ_HOLD` on an event in edge modes.
- `SQ_PULSE` to `SQ_IDLE` on expiry in recurrent modes.
- `SQ_PULSE` to `SQ_SPENT` on expiry in one-shot modes.
- Any state to `SQ_IDLE` on initialise.

Top module: `tc_gpi_event`

## Requirements
- R1: After reset the mode byte is 0x00, the active target is 00:00:00:00, `gpi_drive` is 1, and `evt_seen` and `pulse_busy` are 0. Mode 0x00 means static high output, the equal-and-forward condition, comparison without frames, and the shortest width.
- R2: With mode bit 3 set, all eight BCD digits are compared. With bit 3 clear, the frame byte (`frame_time[7:0]`) is ignored, so a frame with any frame digits matches a target with the same hours, minutes and seconds.
- R3: Mode bits 5..4 select the condition: 0 = time equal to target and `frame_fwd`=1; 1 = time greater than or equal to target and `frame_fwd`=1; 2 = time equal to target, any direction; 3 = time greater than or equal to target, any direction.
- R4: An event occurs on a frame whose condition is true only if, since the last initialise or the last event, at least one frame had a false condition. A condition that stays true on consecutive frames, or is true on the first frame after an initialise, produces no event.
- R5: Kind 2 (recurrent low pulse) idles high and drives low during each pulse. Kind 3 (recurrent high pulse) idles low and drives high. Each new event after a pulse has ended starts a new pulse.
- R6: Kind 4 (one-shot low pulse) and kind 5 (one-shot high pulse) pulse on the first event after an initialise only. Later events leave the output at its idle level until the next initialise.
- R7: Kind 6 (falling edge) idles high and kind 7 (rising edge) idles low. On the first event after an initialise, the output switches to the other level and holds it until the next initialise.
- R8: Mode bits 7..6 set the pulse length to 10, 40, 500 or 1000 `ms_tick` strobes, for codes 0 to 3. `pulse_busy` stays 1 through the first N-1 ticks and falls on the Nth tick.
- R9: An initialise returns the output to the idle level of the current kind, clears `evt_seen`, stops any pulse and disarms the comparator. With `init_load`=1 it also copies the staged hours:minutes (`stage_hm`, upper half) and seconds:frames (`stage_sf`, lower half) into the active target. With `init_load`=0 the active target is unchanged.
- R10: `evt_seen` becomes 1 on the first event after an initialise and stays 1 until the next initialise. `pulse_busy` is 1 exactly while a pulse is running. Both change two clock cycles after the frame strobe that causes the event.
- R11: Kind 0 drives 1 and kind 1 drives 0 at all times. Events in these kinds set `evt_seen` but do not change `gpi_drive`.
- R12: The greater-or-equal comparison treats the packed BCD time as a number with the most significant digit first. For example, 01:19:59:00 is less than target 01:23:45:10, and 02:00:00:00 is greater than it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe, a new frame time is valid |
| frame_time | input | 32 | Packed BCD time hh:mm:ss:ff, hours in the top byte |
| frame_fwd | input | 1 | 1 when the timecode runs forward |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| stage_hm_we | input | 1 | Write strobe for the staged hours:minutes |
| stage_hm | input | 16 | Staged hours:minutes, BCD |
| stage_sf_we | input | 1 | Write strobe for the staged seconds:frames |
| stage_sf | input | 16 | Staged seconds:frames, BCD |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_in | input | 8 | Mode byte: [7:6] width, [5:4] condition, [3] frames, [2:0] kind |
| init_stb | input | 1 | Initialise command |
| init_load | input | 1 | With `init_stb`, load the staged target into the active target |
| gpi_drive | output | 1 | Output level |
| evt_seen | output | 1 | An event occurred since the last initialise |
| pulse_busy | output | 1 | A pulse is running |

## Verification
A stale arming flag in the comparator shows up as an event on a frame that stays true. `evt_seen` and `gpi_drive` then change two cycles after a strobe where both should hold, or fail to change after a false-then-true pair. A counter or width-decode error shows up on the tick count at which `pulse_busy` falls, so it is exposed by the first pulse of each width. A wrong sequencer state shows up on `gpi_drive` after the next event or initialise: a one-shot that pulses twice, an edge that reverts, or an idle level of the wrong polarity. Random frame sequences near the target are compared with a bench model after every operation, so a divergence is reported within one operation.

// File: rtl/tcgpi_pkg.sv
package tcgpi_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_PULSE = 2'd1,
        SQ_HOLD  = 2'd2,
        SQ_SPENT = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [1:0] width;
        logic [1:0] cond;
        logic       frames;
        logic [2:0] kind;
    } mode_t;

    localparam logic [2:0] K_STAT_HI = 3'd0;
    localparam logic [2:0] K_STAT_LO = 3'd1;
    localparam logic [2:0] K_REC_LO  = 3'd2;
    localparam logic [2:0] K_REC_HI  = 3'd3;
    localparam logic [2:0] K_ONE_LO  = 3'd4;
    localparam logic [2:0] K_ONE_HI  = 3'd5;
    localparam logic [2:0] K_FALL    = 3'd6;
    localparam logic [2:0] K_RISE    = 3'd7;

    function automatic logic kind_is_pulse(input logic [2:0] k);
        return (k >= K_REC_LO) && (k <= K_ONE_HI);
    endfunction

    function automatic logic kind_is_edge(input logic [2:0] k);
        return (k == K_FALL) || (k == K_RISE);
    endfunction

    function automatic logic kind_is_recurrent(input logic [2:0] k);
        return (k == K_REC_LO) || (k == K_REC_HI);
    endfunction

endpackage

// File: rtl/tcgpi_regs.sv
module tcgpi_regs
    import tcgpi_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stage_hm_we,
    input  logic [TW/2-1:0] stage_hm,
    input  logic          stage_sf_we,
    input  logic [TW/2-1:0] stage_sf,
    input  logic          mode_we,
    input  logic [7:0]    mode_in,
    input  logic          init_stb,
    input  logic          init_load,
    output logic [TW-1:0] target,
    output mode_t         mode
);
    localparam int HW = TW / 2;

    logic [HW-1:0] hm_q;
    logic [HW-1:0] sf_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hm_q   <= '0;
            sf_q   <= '0;
            target <= '0;
            mode   <= '0;
        end else begin
            if (stage_hm_we) hm_q <= stage_hm;
            if (stage_sf_we) sf_q <= stage_sf;
            if (mode_we)     mode <= mode_t'(mode_in);
            if (init_stb && init_load) target <= {hm_q, sf_q};
        end
    end
endmodule

// File: rtl/tcgpi_match.sv
module tcgpi_match #(
    parameter int TW = 32,
    parameter int FW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_stb,
    input  logic          frame_stb,
    input  logic [TW-1:0] frame_time,
    input  logic          fwd,
    input  logic [TW-1:0] target,
    input  logic          incl_frames,
    input  logic [1:0]    cond_sel,
    output logic          evt_pulse
);
    logic [TW-1:0] cut_t;
    logic [TW-1:0] cut_r;
    logic          rel_ok;
    logic          dir_ok;
    logic          hit;
    logic          armed;

    always_comb begin
        if (incl_frames) begin
            cut_t = frame_time;
            cut_r = target;
        end else begin
            cut_t = {frame_time[TW-1:FW], {FW{1'b0}}};
            cut_r = {target[TW-1:FW], {FW{1'b0}}};
        end
        rel_ok = cond_sel[0] ? (cut_t >= cut_r) : (cut_t == cut_r);
        dir_ok = cond_sel[1] | fwd;
        hit    = rel_ok & dir_ok;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            evt_pulse <= 1'b0;
        end else if (init_stb) begin
            armed     <= 1'b0;
            evt_pulse <= 1'b0;
        end else if (frame_stb) begin
            if (hit) begin
                evt_pulse <= armed;
                armed     <= 1'b0;
            end else begin
                evt_pulse <= 1'b0;
                armed     <= 1'b1;
            end
        end else begin
            evt_pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/tcgpi_width_timer.sv
module tcgpi_width_timer #(
    parameter int W0 = 10,
    parameter int W1 = 40,
    parameter int W2 = 500,
    parameter int W3 = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       start,
    input  logic [1:0] width_sel,
    input  logic       ms_tick,
    output logic       expire
);
    localparam int M01 = (W0 > W1) ? W0 : W1;
    localparam int M23 = (W2 > W3) ? W2 : W3;
    localparam int WMAX = (M01 > M23) ? M01 : M23;
    localparam int CW = $clog2(WMAX + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (width_sel)
            2'd0: load_val = CW'(W0);
            2'd1: load_val = CW'(W1);
            2'd2: load_val = CW'(W2);
            default: load_val = CW'(W3);
        endcase
        expire = ms_tick && (cnt == CW'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= load_val;
        end else if (ms_tick && (cnt != '0)) begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/tcgpi_seq.sv
module tcgpi_seq
    import tcgpi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_stb,
    input  logic       evt,
    input  logic       expire,
    input  logic [2:0] kind,
    output seq_state_e st,
    output logic       start,
    output logic       drive,
    output logic       seen,
    output logic       busy
);
    seq_state_e st_nx;

    always_comb begin
        st_nx = st;
        start = 1'b0;
        if (init_stb) begin
            st_nx = SQ_IDLE;
        end else begin
            unique case (st)
                SQ_IDLE: begin
                    if (evt && kind_is_pulse(kind)) begin
                        st_nx = SQ_PULSE;
                        start = 1'b1;
                    end else if (evt && kind_is_edge(kind)) begin
                        st_nx = SQ_HOLD;
                    end
                end
                SQ_PULSE: begin
                    if (expire) begin
                        st_nx = kind_is_recurrent(kind) ? SQ_IDLE : SQ_SPENT;
                    end
                end
                SQ_HOLD:  st_nx = SQ_HOLD;
                SQ_SPENT: st_nx = SQ_SPENT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SQ_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        seen <= 1'b0;
        else if (init_stb) seen <= 1'b0;
        else if (evt)      seen <= 1'b1;
    end

    always_comb begin
        busy = (st == SQ_PULSE);
        if (kind == K_STAT_HI || kind == K_STAT_LO) begin
            drive = ~kind[0];
        end else begin
            drive = ~kind[0] ^ ((st == SQ_PULSE) || (st == SQ_HOLD));
        end
    end
endmodule

// File: rtl/tc_gpi_event.sv
module tc_gpi_event
    import tcgpi_pkg::*;
#(
    parameter int TC_W  = 32,
    parameter int FRM_W = 8,
    parameter int PW0   = 10,
    parameter int PW1   = 40,
    parameter int PW2   = 500,
    parameter int PW3   = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_stb,
    input  logic [TC_W-1:0]   frame_time,
    input  logic              frame_fwd,
    input  logic              ms_tick,
    input  logic              stage_hm_we,
    input  logic [TC_W/2-1:0] stage_hm,
    input  logic              stage_sf_we,
    input  logic [TC_W/2-1:0] stage_sf,
    input  logic              mode_we,
    input  logic [7:0]        mode_in,
    input  logic              init_stb,
    input  logic              init_load,
    output logic              gpi_drive,
    output logic              evt_seen,
    output logic              pulse_busy
);
    logic [TC_W-1:0] w_target;
    mode_t           w_mode;
    logic            w_evt;
    logic            w_expire;
    logic            w_start;
    seq_state_e      w_state;

    tcgpi_regs #(.TW(TC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .stage_hm_we(stage_hm_we), .stage_hm(stage_hm),
        .stage_sf_we(stage_sf_we), .stage_sf(stage_sf),
        .mode_we(mode_we), .mode_in(mode_in),
        .init_stb(init_stb), .init_load(init_load),
        .target(w_target), .mode(w_mode)
    );

    tcgpi_match #(.TW(TC_W), .FW(FRM_W)) u_match (
        .clk(clk), .rst_n(rst_n), .init_stb(init_stb),
        .frame_stb(frame_stb), .frame_time(frame_time), .fwd(frame_fwd),
        .target(w_target), .incl_frames(w_mode.frames),
        .cond_sel(w_mode.cond), .evt_pulse(w_evt)
    );

    tcgpi_width_timer #(.W0(PW0), .W1(PW1), .W2(PW2), .W3(PW3)) u_timer (
        .clk(clk), .rst_n(rst_n), .clear(init_stb), .start(w_start),
        .width_sel(w_mode.width), .ms_tick(ms_tick), .expire(w_expire)
    );

    tcgpi_seq u_seq (
        .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .evt(w_evt),
        .expire(w_expire), .kind(w_mode.kind), .st(w_state),
        .start(w_start), .drive(gpi_drive), .seen(evt_seen),
        .busy(pulse_busy)
    );
endmodule

// File: rtl/tcgpi_chk.sv
module tcgpi_chk
    import tcgpi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       init_stb,
    input logic       mode_we,
    input logic       ms_tick,
    input logic       evt_pulse,
    input logic       pulse_busy,
    input logic       evt_seen,
    input logic       gpi_drive,
    input seq_state_e st
);
    // R4
    rearm_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);

    // R9
    init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_stb |=> (!evt_seen && !pulse_busy));

    // R10
    busy_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_busy) |-> evt_seen);

    // R8
    width_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_busy && !ms_tick && !init_stb) |=> pulse_busy);

    // R7
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_HOLD && !init_stb && !mode_we) |=> $stable(gpi_drive));

    // R6
    spent_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_SPENT && !init_stb) |=> (st == SQ_SPENT && !pulse_busy));
endmodule

bind tc_gpi_event tcgpi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .init_stb(init_stb), .mode_we(mode_we),
    .ms_tick(ms_tick), .evt_pulse(w_evt), .pulse_busy(pulse_busy),
    .evt_seen(evt_seen), .gpi_drive(gpi_drive), .st(w_state)
);

// File: tb/tc_gpi_event_bench.sv
module tc_gpi_event_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_stb = 1'b0;
    logic [31:0] frame_time = '0;
    logic        frame_fwd = 1'b0;
    logic        ms_tick = 1'b0;
    logic        stage_hm_we = 1'b0;
    logic [15:0] stage_hm = '0;
    logic        stage_sf_we = 1'b0;
    logic [15:0] stage_sf = '0;
    logic        mode_we = 1'b0;
    logic [7:0]  mode_in = '0;
    logic        init_stb = 1'b0;
    logic        init_load = 1'b0;
    logic        gpi_drive;
    logic        evt_seen;
    logic        pulse_busy;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model
    logic [31:0] m_tgt = '0;
    logic [15:0] m_hm = '0;
    logic [15:0] m_sf = '0;
    logic [7:0]  m_mode = '0;
    bit          m_armed = 1'b0;
    bit          m_seen = 1'b0;
    int          m_st = 0;   // 0 idle, 1 pulse, 2 hold, 3 spent
    int          m_cnt = 0;

    always #2 clk = ~clk;

    tc_gpi_event u_tc_gpi_event (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb),
        .frame_time(frame_time), .frame_fwd(frame_fwd), .ms_tick(ms_tick),
        .stage_hm_we(stage_hm_we), .stage_hm(stage_hm),
        .stage_sf_we(stage_sf_we), .stage_sf(stage_sf),
        .mode_we(mode_we), .mode_in(mode_in), .init_stb(init_stb),
        .init_load(init_load), .gpi_drive(gpi_drive),
        .evt_seen(evt_seen), .pulse_busy(pulse_busy)
    );

    function automatic logic [7:0] bcd2(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int width_ticks(input logic [1:0] w);
        case (w)
            2'd0: return 10;
            2'd1: return 40;
            2'd2: return 500;
            default: return 1000;
        endcase
    endfunction

    function automatic bit model_cond(input logic [31:0] t, input bit fw);
        logic [31:0] a, b;
        bit rel;
        a = m_mode[3] ? t : {t[31:8], 8'h00};
        b = m_mode[3] ? m_tgt : {m_tgt[31:8], 8'h00};
        rel = m_mode[4] ? (a >= b) : (a == b);
        return rel && (m_mode[5] || fw);
    endfunction

    function automatic bit model_drive();
        logic [2:0] k;
        k = m_mode[2:0];
        if (k < 3'd2) return ~k[0];
        return ~k[0] ^ ((m_st == 1) || (m_st == 2));
    endfunction

    task automatic chk_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk_bit({tag, " drive"}, gpi_drive, model_drive());
        chk_bit({tag, " seen"}, evt_seen, m_seen);
        chk_bit({tag, " busy"}, pulse_busy, m_st == 1);
    endtask

    task automatic t_stage(input logic [15:0] hm, input logic [15:0] sf);
        @(negedge clk);
        stage_hm_we = 1'b1; stage_hm = hm;
        stage_sf_we = 1'b1; stage_sf = sf;
        @(negedge clk);
        stage_hm_we = 1'b0; stage_sf_we = 1'b0;
        m_hm = hm; m_sf = sf;
    endtask

    task automatic t_mode(input logic [7:0] v);
        @(negedge clk);
        mode_we = 1'b1; mode_in = v;
        @(negedge clk);
        mode_we = 1'b0;
        m_mode = v;
    endtask

    task automatic t_init(input bit load);
        @(negedge clk);
        init_stb = 1'b1; init_load = load;
        @(negedge clk);
        init_stb = 1'b0; init_load = 1'b0;
        m_armed = 1'b0; m_seen = 1'b0; m_st = 0; m_cnt = 0;
        if (load) m_tgt = {m_hm, m_sf};
    endtask

    task automatic t_frame(input logic [31:0] t, input bit fw);
        bit c, ev;
        @(negedge clk);
        frame_stb = 1'b1; frame_time = t; frame_fwd = fw;
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
        c = model_cond(t, fw);
        ev = c && m_armed;
        m_armed = !c;
        if (ev) begin
            m_seen = 1'b1;
            if (m_st == 0) begin
                if (m_mode[2:0] >= 3'd2 && m_mode[2:0] <= 3'd5) begin
                    m_st = 1; m_cnt = width_ticks(m_mode[7:6]);
                end else if (m_mode[2:0] >= 3'd6) begin
                    m_st = 2;
                end
            end
        end
    endtask

    task automatic t_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            if (m_st == 1 && m_cnt == 1) begin
                m_st = (m_mode[2:0] == 3'd2 || m_mode[2:0] == 3'd3) ? 0 : 3;
            end
            if (m_cnt != 0) m_cnt--;
        end
    endtask

    localparam logic [31:0] TGT   = 32'h01234510;
    localparam logic [31:0] BELOW = 32'h01234400;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk_bit("R1 reset drive", gpi_drive, 1'b1);
        chk_bit("R1 reset seen", evt_seen, 1'b0);
        chk_bit("R1 reset busy", pulse_busy, 1'b0);

        // R1 default target 00:00:00:00 with equal-forward, no frames
        t_frame(32'h00000000, 1'b1);
        chk_bit("R1 first true frame no event", evt_seen, 1'b0);
        t_frame(32'h00000100, 1'b1);
        t_frame(32'h00000017, 1'b1);
        chk_bit("R1 R11 default event seen", evt_seen, 1'b1);
        chk_bit("R11 static high kept", gpi_drive, 1'b1);

        // R9 load target, R5 recurrent low pulse
        t_stage(16'h0123, 16'h4510);
        t_mode(8'h02);
        t_init(1'b1);
        chk_all("R9 init");
        t_frame(TGT, 1'b1);
        chk_bit("R4 true after init no event", evt_seen, 1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(32'h01234503, 1'b1);
        chk_bit("R2 frames masked event", evt_seen, 1'b1);
        chk_bit("R5 low pulse drive", gpi_drive, 1'b0);
        chk_bit("R10 busy", pulse_busy, 1'b1);
        t_tick(9);
        chk_bit("R8 busy after 9 ticks", pulse_busy, 1'b1);
        t_tick(1);
        chk_bit("R8 ends on tick 10", pulse_busy, 1'b0);
        chk_bit("R5 back high", gpi_drive, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R4 steady true no retrigger", pulse_busy, 1'b0);
        t_frame(TGT, 1'b0);
        chk_bit("R3 reverse blocks", pulse_busy, 1'b0);
        t_frame(TGT, 1'b1);
        chk_bit("R3 R5 forward retrigger", pulse_busy, 1'b1);
        t_tick(10);
        chk_all("R5 recurrent done");

        // R2 frames included
        t_mode(8'h0B);
        t_init(1'b0);
        chk_bit("R5 high pulse idle low", gpi_drive, 1'b0);
        t_frame(32'h01234509, 1'b1);
        t_frame(32'h01234511, 1'b1);
        chk_bit("R2 frame mismatch no event", evt_seen, 1'b0);
        t_frame(TGT, 1'b1);
        chk_bit("R2 exact frame event", gpi_drive, 1'b1);
        t_tick(10);

        // R3 R12 greater-or-equal any direction
        t_mode(8'h33);
        t_init(1'b0);
        t_frame(32'h01195900, 1'b0);
        chk_bit("R12 lower time no event", evt_seen, 1'b0);
        t_frame(32'h02000000, 1'b0);
        chk_bit("R12 R3 greater reverse event", gpi_drive, 1'b1);
        t_tick(10);
        // R3 ge with forward required, reverse
        t_mode(8'h13);
        t_init(1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(32'h02000000, 1'b0);
        chk_bit("R3 ge-forward reverse no event", evt_seen, 1'b0);
        t_frame(32'h02000000, 1'b1);
        chk_bit("R3 ge-forward event", pulse_busy, 1'b1);
        t_tick(10);

        // R6 one-shot low
        t_mode(8'h04);
        t_init(1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R6 one-shot pulse", gpi_drive, 1'b0);
        t_tick(10);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R6 second event ignored busy", pulse_busy, 1'b0);
        chk_bit("R6 second event drive", gpi_drive, 1'b1);
        t_init(1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R6 after init pulses", pulse_busy, 1'b1);
        t_tick(10);
        chk_all("R6 one-shot done");

        // R7 falling and rising edges
        t_mode(8'h06);
        t_init(1'b0);
        chk_bit("R7 fall idle", gpi_drive, 1'b1);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        t_tick(20);
        chk_bit("R7 fall held", gpi_drive, 1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R7 fall still held", gpi_drive, 1'b0);
        t_init(1'b0);
        chk_bit("R9 init restores idle", gpi_drive, 1'b1);
        t_mode(8'h07);
        chk_bit("R7 rise idle", gpi_drive, 1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R7 rise", gpi_drive, 1'b1);
        t_init(1'b0);

        // R8 widths
        for (int w = 1; w < 4; w++) begin
            int n;
            n = width_ticks(2'(w));
            t_mode({2'(w), 6'h02});
            t_init(1'b0);
            t_frame(BELOW, 1'b1);
            t_frame(TGT, 1'b1);
            t_tick(n - 1);
            chk_bit($sformatf("R8 width %0d before end", n), pulse_busy, 1'b1);
            t_tick(1);
            chk_bit($sformatf("R8 width %0d ended", n), pulse_busy, 1'b0);
        end

        // R9 load=0 keeps target, load=1 takes staged
        t_mode(8'h02);
        t_stage(16'h0500, 16'h0000);
        t_init(1'b0);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R9 no-load keeps target", evt_seen, 1'b1);
        t_init(1'b1);
        t_frame(BELOW, 1'b1);
        t_frame(TGT, 1'b1);
        chk_bit("R9 old target gone", evt_seen, 1'b0);
        t_frame(32'h05000012, 1'b1);
        chk_bit("R9 new target hit", evt_seen, 1'b1);
        t_tick(10);

        // R11 static low
        t_mode(8'h01);
        t_init(1'b0);
        t_frame(32'h04000000, 1'b1);
        t_frame(32'h05000000, 1'b1);
        chk_bit("R11 static low seen", evt_seen, 1'b1);
        chk_bit("R11 static low drive", gpi_drive, 1'b0);

        // random phase against model
        t_stage(16'h0123, 16'h4510);
        t_init(1'b1);
        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 12;
            if (op == 0) begin
                t_init(1'($urandom % 2));
                chk_all("R9 random init");
            end else if (op == 1) begin
                t_mode(8'($urandom) & 8'h7F);
                chk_all("R11 random mode");
            end else if (op < 5) begin
                t_tick(1 + $urandom % 6);
                chk_all("R8 random tick");
            end else begin
                t_frame({16'h0123, bcd2(44 + $urandom % 3), bcd2(9 + $urandom % 3)},
                        ($urandom % 4) != 0);
                chk_all("R4 random frame");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule